// File: doc/BRIEF.md
# Delay Line Length Calibration Sequencer

This block runs the first stage of sampling-clock alignment for a programmable delay line. Before any phase sweep can start, the line has to be trimmed so that the span of its taps covers one input clock period. The sequencer does this in hardware. It walks a unit-delay code upward from zero. For each code it puts the line into its measuring mode and waits for the line to report a length vector. It stops at the first code whose vector is usable.

It returns two results. The first is the winning unit code. The second is the bit position of the highest set bit in the measured vector, which a later phase stage uses as its largest selectable phase. A single-cycle `start` begins a run. The run ends with either `done` or `error`, and that output stays high until the next `start`.

The delay-line side has the form of a small register port: two enable levels, a configuration load strobe carrying the select and unit fields, and the returned valid flag and length vector.

The state machine has six states:
- IDLE: waits after reset.
- ENABLE: both enables are raised.
- CONFIG: one load strobe is driven with the unit code and the measurement select.
- WAIT: the valid flag is sampled once per clock under a timeout.
- FINISH: success.
- FAIL: every code failed.

Its transitions are:
- start: IDLE, FINISH or FAIL go to ENABLE.
- arm: ENABLE goes to CONFIG.
- write: CONFIG goes to WAIT.
- accept: WAIT goes to FINISH on a usable length.
- skip: WAIT goes to ENABLE on an unusable length or on timeout, when codes remain.
- exhaust: WAIT goes to FAIL on an unusable length or on timeout at the last code.

Top module: `dlcal_seq`

## Requirements
- R1: After reset, `done`, `error`, `dl_en`, `dl_sampler` and `dl_load` are all low.
- R2: Both `dl_en` and `dl_sampler` are high in the cycle before every `dl_load` pulse and in the cycle of that pulse.
- R3: Every `dl_load` pulse carries `dl_sel` equal to TAPS+1. With the default of 11 taps this is 12.
- R4: The unit codes presented with successive `dl_load` pulses of one run are 0, 1, 2 and so on, rising by one per attempt.
- R5: When no valid flag arrives, the sequencer waits exactly TMO_CYC = CYC_PER_US*TIMEOUT_US cycles in WAIT before it skips to the next code. The spacing between two successive loads is then TMO_CYC+2 cycles.
- R6: A valid flag seen in the last WAIT cycle before expiry is accepted. A flag arriving one cycle later is not, and that code is skipped.
- R7: A length is usable only if it is nonzero and below 2^TAPS. A flagged but unusable length makes the sequencer skip to the next code.
- R8: On the first usable length the run ends with `done` high, and `cal_unit` equals the unit code of that attempt. No further load follows.
- R9: `cal_max_phase` equals the bit index of the most significant set bit of the usable length.
- R10: If no code from 0 to 2^UNIT_W-1 gives a usable length, `error` goes high after exactly 2^UNIT_W loads.
- R11: `done` and `error` are never high together. Whichever was raised stays high until the next `start`, and a new `start` runs a fresh sweep from code 0.
- R12: A `start` pulse during a run has no effect. The load sequence and the result are the same as without it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request to begin a calibration run |
| done | output | 1 | Calibration succeeded; held until next start |
| error | output | 1 | No usable code found; held until next start |
| cal_unit | output | UNIT_W | Winning unit-delay code |
| cal_max_phase | output | SEL_W | Index of the highest set bit of the usable length |
| dl_en | output | 1 | Delay-line enable level |
| dl_sampler | output | 1 | Delay-line measuring (sampler) enable level |
| dl_load | output | 1 | Single-cycle strobe writing dl_sel and dl_unit into the line |
| dl_sel | output | SEL_W | Phase select field; TAPS+1 while measuring |
| dl_unit | output | UNIT_W | Unit-delay code field |
| dl_len_valid | input | 1 | Length-valid flag returned by the line |
| dl_len | input | LEN_W | Measured length vector returned by the line |

## Verification
Two functions can fall in the same WAIT cycle: the arrival of the valid flag and the expiry of the timeout. The bench's line model lets the flag latency be set per case. A latency that puts the flag exactly on the final timeout cycle must give acceptance at the flagged code. A latency one cycle longer must make every code time out and end in `error` after the full count of loads. For the timeout path, the spacing between loads is also measured and must equal the timeout plus two cycles.

// File: rtl/dlcal_pkg.sv
package dlcal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENABLE,
        ST_CONFIG,
        ST_WAIT,
        ST_FINISH,
        ST_FAIL
    } dlcal_state_t;

endpackage

// File: rtl/dlcal_wait_timer.sv
module dlcal_wait_timer #(
    parameter int unsigned LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (!expired) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R5: the count never runs past the last wait cycle
    assert_wait_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q <= CW'(LIMIT - 1)));

endmodule

// File: rtl/dlcal_msb.sv
module dlcal_msb #(
    parameter int unsigned W  = 12,
    parameter int unsigned IW = 4
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx
);
    logic [W-1:0] top;

    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_top
            if (gi == W - 1) begin : g_last
                assign top[gi] = vec[gi];
            end else begin : g_mid
                assign top[gi] = vec[gi] & ~(|vec[W-1:gi+1]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < W; i++) begin
            if (top[i]) idx = idx | IW'(i);
        end
    end

endmodule

// File: rtl/dlcal_seq.sv
module dlcal_seq
    import dlcal_pkg::*;
#(
    parameter int unsigned TAPS       = 11,
    parameter int unsigned LEN_W      = 12,
    parameter int unsigned UNIT_W     = 7,
    parameter int unsigned SEL_W      = 4,
    parameter int unsigned CYC_PER_US = 100,
    parameter int unsigned TIMEOUT_US = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              error,
    output logic [UNIT_W-1:0] cal_unit,
    output logic [SEL_W-1:0]  cal_max_phase,
    output logic              dl_en,
    output logic              dl_sampler,
    output logic              dl_load,
    output logic [SEL_W-1:0]  dl_sel,
    output logic [UNIT_W-1:0] dl_unit,
    input  logic              dl_len_valid,
    input  logic [LEN_W-1:0]  dl_len
);
    localparam int unsigned TMO_CYC  = CYC_PER_US * TIMEOUT_US;
    localparam int unsigned SEL_PAST = TAPS + 1;
    localparam logic [UNIT_W-1:0] UNIT_LAST = {UNIT_W{1'b1}};

    dlcal_state_t state_q, state_d;
    logic [UNIT_W-1:0] unit_q;
    logic              tmo_hit;
    logic              len_ok;
    logic [SEL_W-1:0]  msb_idx;
    logic              at_rest;
    logic              last_code;

    dlcal_wait_timer #(.LIMIT(TMO_CYC)) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state_q == ST_WAIT),
        .expired(tmo_hit)
    );

    dlcal_msb #(.W(LEN_W), .IW(SEL_W)) i_msb (
        .vec(dl_len),
        .idx(msb_idx)
    );

    assign len_ok    = (|dl_len) && (dl_len[LEN_W-1:TAPS] == '0);
    assign at_rest   = (state_q == ST_IDLE) || (state_q == ST_FINISH) || (state_q == ST_FAIL);
    assign last_code = (unit_q == UNIT_LAST);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISH, ST_FAIL: if (start) state_d = ST_ENABLE;
            ST_ENABLE: state_d = ST_CONFIG;
            ST_CONFIG: state_d = ST_WAIT;
            ST_WAIT: begin
                if (dl_len_valid && len_ok) begin
                    state_d = ST_FINISH;
                end else if (dl_len_valid || tmo_hit) begin
                    state_d = last_code ? ST_FAIL : ST_ENABLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and sweep registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            unit_q        <= '0;
            cal_unit      <= '0;
            cal_max_phase <= '0;
        end else begin
            state_q <= state_d;
            if (at_rest && start) begin
                unit_q <= '0;
            end else if (state_q == ST_WAIT && state_d == ST_ENABLE) begin
                unit_q <= unit_q + 1'b1;
            end
            if (state_q == ST_WAIT && state_d == ST_FINISH) begin
                cal_unit      <= unit_q;
                cal_max_phase <= msb_idx;
            end
        end
    end

    // outputs
    always_comb begin
        done       = 1'b0;
        error      = 1'b0;
        dl_en      = 1'b0;
        dl_sampler = 1'b0;
        dl_load    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ENABLE, ST_WAIT: begin
                dl_en      = 1'b1;
                dl_sampler = 1'b1;
            end
            ST_CONFIG: begin
                dl_en      = 1'b1;
                dl_sampler = 1'b1;
                dl_load    = 1'b1;
            end
            ST_FINISH: begin
                dl_en      = 1'b1;
                dl_sampler = 1'b1;
                done       = 1'b1;
            end
            ST_FAIL: error = 1'b1;
            default: ;
        endcase
    end

    assign dl_sel  = SEL_W'(SEL_PAST);
    assign dl_unit = unit_q;

    // R2: enables were already up the cycle before a load
    assert_enable_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dl_load |-> (dl_en && dl_sampler && $past(dl_en && dl_sampler)));

    // R4: each re-arm presents the next code
    assert_unit_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ENABLE && $past(state_q == ST_WAIT)) |-> (unit_q == $past(unit_q) + 1'b1));

    // R8: result latches the code of the accepted attempt
    assert_result_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (cal_unit == $past(unit_q)));

    // R11: completion flags are exclusive and held
    assert_flags_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    assert_done_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);
    assert_error_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

    // R10: failure only follows the last code
    assert_fail_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> ($past(unit_q) == UNIT_LAST));

endmodule

// File: tb/test_dlcal_seq.sv
module test_dlcal_seq;
    localparam int unsigned TAPS  = 11;
    localparam int unsigned LEN_W = 12;
    localparam int unsigned UW    = 7;
    localparam int unsigned SW    = 4;
    localparam int unsigned CPU   = 2;
    localparam int unsigned TUS   = 5;
    localparam int unsigned TMO   = CPU * TUS;
    localparam int unsigned NCODE = 1 << UW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic done, error, dl_en, dl_sampler, dl_load;
    logic [UW-1:0] cal_unit, dl_unit;
    logic [SW-1:0] cal_max_phase, dl_sel;
    logic dl_len_valid;
    logic [LEN_W-1:0] dl_len;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    dlcal_seq #(.TAPS(TAPS), .LEN_W(LEN_W), .UNIT_W(UW), .SEL_W(SW),
                .CYC_PER_US(CPU), .TIMEOUT_US(TUS)) i_dlcal_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .done(done), .error(error),
        .cal_unit(cal_unit), .cal_max_phase(cal_max_phase),
        .dl_en(dl_en), .dl_sampler(dl_sampler), .dl_load(dl_load),
        .dl_sel(dl_sel), .dl_unit(dl_unit),
        .dl_len_valid(dl_len_valid), .dl_len(dl_len)
    );

    // delay-line model
    int m_good = 0;
    int m_mode = 0;
    int m_lat  = 3;
    logic [LEN_W-1:0] m_len = '0;
    int m_cnt = 0;
    logic m_flag;
    logic [LEN_W-1:0] m_val;

    always_comb begin
        m_flag = 1'b1;
        m_val  = '0;
        if (int'(dl_unit) == m_good) begin
            m_val = m_len;
        end else begin
            case (m_mode)
                0: m_val = '0;
                1: m_val = 12'h800 | LEN_W'(dl_unit);
                2: m_flag = 1'b0;
                default: begin
                    if (dl_unit[0]) m_val = 12'hFFF;
                    else m_flag = 1'b0;
                end
            endcase
        end
    end

    always @(posedge clk) begin
        if (dl_load) begin
            dl_len_valid <= 1'b0;
            m_cnt <= m_lat;
        end else if (m_cnt > 0) begin
            if (m_cnt == 1 && m_flag) begin
                dl_len_valid <= 1'b1;
                dl_len <= m_val;
            end
            m_cnt <= m_cnt - 1;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // load monitor
    int  loads = 0;
    int  last_load_cyc = 0;
    bit  prev_en = 1'b0;
    bit  gap_chk = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n && dl_load) begin
            check(dl_unit == UW'(loads), "R4 unit order", int'(dl_unit), loads);
            check(dl_sel == SW'(TAPS + 1), "R3 select", int'(dl_sel), TAPS + 1);
            check(prev_en && dl_en && dl_sampler, "R2 enables before load", int'(prev_en), 1);
            if (gap_chk && loads > 0 && loads <= m_good)
                check(cyc - last_load_cyc == int'(TMO) + 2, "R5 timeout spacing",
                      cyc - last_load_cyc, TMO + 2);
            last_load_cyc = cyc;
            loads++;
        end
        prev_en = dl_en && dl_sampler;
    end

    initial begin
        dl_len_valid = 1'b0;
        dl_len = '0;
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    function automatic int msb_of(input logic [LEN_W-1:0] v);
        for (int i = LEN_W - 1; i >= 0; i--) if (v[i]) return i;
        return 0;
    endfunction

    task automatic run_case(input int good, input logic [LEN_W-1:0] len, input int mode,
                            input int lat, input bit poke);
        bit exp_ok;
        int exp_loads;
        int guard;
        m_good = good; m_len = len; m_mode = mode; m_lat = lat;
        gap_chk = (mode == 2);
        exp_ok = (good < NCODE) && (lat <= int'(TMO) - 1) && (len != 0) && (len < (1 << TAPS));
        exp_loads = exp_ok ? good + 1 : NCODE;
        @(negedge clk);
        loads = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (!(done || error) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check(done == exp_ok, exp_ok ? "R8 done" : "R10 error", int'(done), int'(exp_ok));
        check(error == !exp_ok, "R10 error flag", int'(error), int'(!exp_ok));
        check(!(done && error), "R11 exclusive", int'(done && error), 0);
        if (exp_ok) begin
            check(int'(cal_unit) == good, "R8 unit", int'(cal_unit), good);
            check(int'(cal_max_phase) == msb_of(len), "R9 max phase", int'(cal_max_phase), msb_of(len));
        end
        repeat (4) @(negedge clk);
        check(loads == exp_loads, poke ? "R12 loads with stray start" : "R7 load count", loads, exp_loads);
        check(done == exp_ok && error == !exp_ok, "R11 held", int'(done), int'(exp_ok));
        gap_chk = 1'b0;
    endtask

    // vectors: good[7:0] len[11:0] mode[1:0] lat[7:0]
    localparam logic [29:0] VEC [8] = '{
        {8'd0,   12'h001, 2'd0, 8'd3},
        {8'd5,   12'h7FF, 2'd0, 8'd2},
        {8'd3,   12'h0A0, 2'd1, 8'd3},
        {8'd4,   12'h010, 2'd2, 8'd9},
        {8'd127, 12'h400, 2'd3, 8'd1},
        {8'd200, 12'h000, 2'd1, 8'd2},
        {8'd2,   12'h020, 2'd0, 8'd10},
        {8'd6,   12'h003, 2'd1, 8'd9}
    };

    initial begin
        repeat (3) @(negedge clk);
        check(!done && !error, "R1 flags at reset", int'(done || error), 0);
        check(!dl_en && !dl_sampler && !dl_load, "R1 line idle at reset", int'(dl_en), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!done && !error && !dl_load, "R1 idle after release", int'(done), 0);

        for (int k = 0; k < 8; k++) begin
            run_case(int'(VEC[k][29:22]), VEC[k][21:10], int'(VEC[k][9:8]), int'(VEC[k][7:0]), 1'b0);
        end

        // R6: flag in last wait cycle accepted at code 0; one cycle later misses every code
        run_case(0, 12'h100, 0, int'(TMO) - 1, 1'b0);
        run_case(0, 12'h100, 0, int'(TMO), 1'b0);
        // R7: length exactly 2^TAPS unusable, all codes
        run_case(300, 12'h000, 1, 2, 1'b0);
        // R12: stray start mid-run
        run_case(9, 12'h044, 0, 3, 1'b1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule